// File: doc/BRIEF.md
# Serial Byte Transmitter with Transmit Queue

This block sends bytes on one asynchronous serial line. Software, or a DMA engine, fills a byte queue through a small register bus. The transmitter then sends each byte as a frame with one start bit, eight data bits and one stop bit. The pace is set by a one-cycle bit tick from an external baud generator, and each bit lasts one tick period.

A sticky "queue low" status flag tells the writer when there is room. The flag sets once the number of stored bytes falls to a selectable trigger level or below, so one burst can refill the queue with up to depth minus trigger bytes. Software clears the flag with a read-then-clear handshake. A DMA write clears it without that handshake. The flag, gated by an enable bit, drives one request line that can serve as an interrupt or a DMA request.

An end-of-transmission flag shows that the queue is empty and the last stop bit has finished. A break can be held on the line: set the break bit while the transmitter is disabled, and the line is driven low until the break bit is released.

Top module: `txq_uart`

## Requirements
- R1: The queue holds DEPTH (16) bytes. A read of address 3 returns the stored byte count in bits [15:8], with bits [7:0] at zero.
- R2: A byte written while the queue holds DEPTH bytes is dropped. The count and the transmitted byte stream are unchanged.
- R3: Each frame on `txd` is one low start bit, then data bits LSB first, then one high stop bit, each lasting one `bit_tick` period. Bytes leave in write order, back-to-back frames are allowed, and the idle line is high.
- R4: Status bit 0 (queue-low flag, reset value 1) sets when the count is at or below the trigger level 1 << CTRL[3:2], giving levels 1, 2, 4 or 8. It stays set until it is cleared.
- R5: Writing 0 to status bit 0 clears the flag only if a read of address 2 has returned bit 0 = 1 since the flag last cleared. Any other write to the status register has no effect.
- R6: A `dma_wr` pulse pushes `dma_data` and clears the queue-low flag without any read. When a DMA write and a CPU data write fall in the same cycle, the DMA byte is stored and the CPU byte is dropped.
- R7: Status bit 1 (transmit-end, reset value 1) clears on every accepted push. It sets once the queue is empty and the stop bit of the last frame has finished.
- R8: `tx_req` is high exactly while the queue-low flag and CTRL[1] (request enable) are both 1.
- R9: New frames start only while CTRL[0] (transmit enable) is 1. Clearing CTRL[0] during a frame lets that frame complete.
- R10: While CTRL[4] (break) is 1 and CTRL[0] is 0, `txd` is held low and any frame in progress is abandoned. Clearing CTRL[4] returns the line high.
- R11: A read returns its data on `bus_rdata` one cycle after `bus_rd`. Address 0 is the data write port and reads as 0. Address 1 reads back CTRL[4:0]. Address 2 returns {transmit-end, queue-low} in bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, registered |
| dma_wr | input | 1 | DMA push strobe |
| dma_data | input | DW | DMA push byte |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial output, idles high |
| tx_req | output | 1 | Interrupt/DMA request |

## Verification
The bench builds the block with its defaults: DEPTH 16, 8-bit data and a 16-bit bus. It pulses `bit_tick` every 8 clocks, so a frame takes 80 cycles. This keeps every trigger level, a completely full queue, the overflow drop and the transition from count 9 to count 8 at the top trigger within a short run. Randomly sized bursts with random trigger levels then exercise the flag after a clear against the count it leaves behind.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    A_DATA = 2'd0,
    A_CTRL = 2'd1,
    A_STAT = 2'd2,
    A_CNT  = 2'd3
  } reg_addr_e;

  // bit 4 break, bits 3:2 trigger select, bit 1 request enable, bit 0 transmit enable
  typedef struct packed {
    logic       brk;
    logic [1:0] trig_sel;
    logic       irq_en;
    logic       tx_en;
  } ctrl_t;

  localparam int CTRL_W = 5;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdat,
  input  logic          pop,
  output logic [DW-1:0] rdat,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic          pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdat;
  end

  assign rdat = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_nxt;
      if (pop_ok)  rd_ptr <= rd_nxt;
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_full_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == $past(count)));
  p_pop_has_data_r3: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/txq_shifter.sv
module txq_shifter #(
  parameter int DW = 8,
  localparam int NBITS = DW + 2,
  localparam int BCW   = $clog2(NBITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          abort,
  input  logic          has_data,
  input  logic [DW-1:0] byte_in,
  output logic          pop,
  output logic          ser_bit,
  output logic          busy
);
  logic [DW:0]    sh;
  logic [BCW-1:0] bcnt;
  logic           last, start;

  assign last  = busy && (bcnt == BCW'(NBITS - 1));
  assign start = tick && tx_en && has_data && !abort && (!busy || last);
  assign pop   = start;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      ser_bit <= 1'b1;
      sh      <= '1;
      bcnt    <= '0;
    end else if (abort) begin
      busy    <= 1'b0;
      ser_bit <= 1'b1;
      bcnt    <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      ser_bit <= 1'b0;
      sh      <= {1'b1, byte_in};
      bcnt    <= '0;
    end else if (busy && tick) begin
      if (last) begin
        busy    <= 1'b0;
        ser_bit <= 1'b1;
        bcnt    <= '0;
      end else begin
        ser_bit <= sh[0];
        sh      <= {1'b1, sh[DW:1]};
        bcnt    <= bcnt + 1'b1;
      end
    end
  end

  p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !ser_bit);
  p_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ser_bit);
  p_no_start_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !busy) |=> !busy);
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int CW     = 5,
  parameter int TRIG_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     count,
  input  logic [TRIG_W-1:0] trig_sel,
  input  logic              stat_rd,
  input  logic              stat_clr,
  input  logic              dma_clr,
  input  logic              push_acc,
  input  logic              q_empty,
  input  logic              tx_busy,
  input  logic              irq_en,
  output logic              fe,
  output logic              tend,
  output logic              req
);
  logic [CW-1:0] trig;
  logic          armed, sw_ok, fe_kill;

  assign trig    = CW'(1) << trig_sel;
  assign sw_ok   = stat_clr && armed;
  assign fe_kill = sw_ok || dma_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      fe    <= 1'b1;
      armed <= 1'b0;
      tend  <= 1'b1;
      req   <= 1'b0;
    end else begin
      if (fe_kill)            fe <= 1'b0;
      else if (count <= trig) fe <= 1'b1;

      if (fe_kill)            armed <= 1'b0;
      else if (stat_rd && fe) armed <= 1'b1;

      if (push_acc)                tend <= 1'b0;
      else if (q_empty && !tx_busy) tend <= 1'b1;

      req <= fe && irq_en;
    end
  end

  p_clear_needs_read_r5: assert property (@(posedge clk) disable iff (rst)
    (fe && !armed && !dma_clr) |=> fe);
  p_dma_clears_r6: assert property (@(posedge clk) disable iff (rst)
    dma_clr |=> !fe);
  p_push_clears_tend_r7: assert property (@(posedge clk) disable iff (rst)
    push_acc |=> !tend);
  p_req_gated_r8: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !req);
endmodule

// File: rtl/txq_uart.sv
module txq_uart
  import txq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DW     = 8,
  parameter int BUS_W  = 16,
  parameter int TRIG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             dma_wr,
  input  logic [DW-1:0]    dma_data,
  input  logic             bit_tick,
  output logic             txd,
  output logic             tx_req
);
  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int HALF = BUS_W / 2;

  ctrl_t         ctrl_q;
  logic          cpu_push, push_req, push_acc, brk_act;
  logic [DW-1:0] push_byte, head;
  logic [CW-1:0] count;
  logic          full, empty, pop, ser_bit, busy;
  logic          fe, tend, stat_rd, stat_clr;
  logic [BUS_W-1:0] rd_d;
  logic          unused_hi;

  assign unused_hi = ^bus_wdata[BUS_W-1:DW];

  assign cpu_push  = bus_wr && (bus_addr == A_DATA);
  assign push_req  = cpu_push || dma_wr;
  assign push_byte = dma_wr ? dma_data : bus_wdata[DW-1:0];
  assign stat_rd   = bus_rd && (bus_addr == A_STAT);
  assign stat_clr  = bus_wr && (bus_addr == A_STAT) && !bus_wdata[0];
  assign brk_act   = ctrl_q.brk && !ctrl_q.tx_en;

  always_ff @(posedge clk) begin
    if (rst)                                ctrl_q <= '0;
    else if (bus_wr && bus_addr == A_CTRL)  ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  txq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst), .push(push_req), .wdat(push_byte), .pop(pop),
    .rdat(head), .count(count), .full(full), .empty(empty), .push_ok(push_acc)
  );

  txq_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .tick(bit_tick), .tx_en(ctrl_q.tx_en), .abort(brk_act),
    .has_data(!empty), .byte_in(head), .pop(pop), .ser_bit(ser_bit), .busy(busy)
  );

  txq_flags #(.CW(CW), .TRIG_W(TRIG_W)) u_flags (
    .clk(clk), .rst(rst), .count(count), .trig_sel(ctrl_q.trig_sel),
    .stat_rd(stat_rd), .stat_clr(stat_clr), .dma_clr(dma_wr), .push_acc(push_acc),
    .q_empty(empty), .tx_busy(busy), .irq_en(ctrl_q.irq_en),
    .fe(fe), .tend(tend), .req(tx_req)
  );

  always_comb begin
    rd_d = '0;
    unique case (bus_addr)
      A_CTRL:  rd_d[CTRL_W-1:0] = ctrl_q;
      A_STAT:  rd_d[1:0]        = {tend, fe};
      A_CNT:   rd_d[HALF +: CW] = count;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_d;
  end

  always_ff @(posedge clk) begin
    if (rst) txd <= 1'b1;
    else     txd <= brk_act ? 1'b0 : ser_bit;
  end

  p_break_low_r10: assert property (@(posedge clk) disable iff (rst)
    (brk_act && $past(brk_act)) |-> !txd);
  p_dma_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (dma_wr && cpu_push && !full) |-> push_acc);
endmodule

// File: tb/txq_uart_test.sv
module txq_uart_test;
  localparam int TDIV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, dma_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  dma_data = '0;
  logic        bit_tick;
  logic        txd, tx_req;
  logic [3:0]  tcnt;

  int total = 0, fails = 0;
  bit done = 0;
  logic [7:0] rxq[$];
  logic [7:0] expq[$];

  always #10 clk = ~clk;

  txq_uart uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_wr(dma_wr), .dma_data(dma_data),
    .bit_tick(bit_tick), .txd(txd), .tx_req(tx_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin tcnt <= '0; bit_tick <= 1'b0; end
    else begin
      tcnt     <= (tcnt == 4'(TDIV - 1)) ? '0 : tcnt + 1'b1;
      bit_tick <= (tcnt == 4'(TDIV - 1));
    end
  end

  function automatic int trig_of(int sel); return 1 << sel; endfunction
  function automatic bit fe_after_clear(int n, int sel); return n <= trig_of(sel); endfunction
  function automatic logic [15:0] cw(bit en, bit ien, int sel, bit brk);
    return {11'b0, brk, 2'(sel), ien, en};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bwr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic brd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask
  task automatic dwr(logic [7:0] d);
    @(negedge clk); dma_wr = 1; dma_data = d;
    @(negedge clk); dma_wr = 0;
  endtask
  task automatic waitn(int n); repeat (n) @(negedge clk); endtask
  task automatic wait_rx(int n); while (rxq.size() < n) @(negedge clk); endtask
  task automatic cmp_rx(string req);
    chk(rxq.size() == expq.size(), req, "frame count", rxq.size(), expq.size());
    for (int i = 0; i < expq.size() && i < rxq.size(); i++)
      chk(rxq[i] == expq[i], req, "frame byte", rxq[i], expq[i]);
  endtask

  // serial line decoder, samples mid-bit
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (!rst && txd === 1'b0) begin
        repeat (TDIV / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin repeat (TDIV) @(negedge clk); b[i] = txd; end
        repeat (TDIV) @(negedge clk);
        if (txd === 1'b1) rxq.push_back(b);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  x;
    void'($urandom(32'd7305));
    waitn(5); rst = 0; waitn(2);

    chk(txd === 1'b1, "R3", "idle line", txd, 1);
    chk(tx_req === 1'b0, "R8", "req at reset", tx_req, 0);
    bwr(2'd2, 16'h0000);                       // clear attempt with no prior read
    brd(2'd2, v); chk(v == 16'h0003, "R5", "unarmed clear ignored / reset status R4 R7", v, 3);
    brd(2'd3, v); chk(v == 16'h0000, "R1", "reset count", v, 0);

    bwr(2'd1, cw(0, 1, 3, 0));
    brd(2'd1, v); chk(v == 16'h000E, "R11", "ctrl readback", v, 16'h000E);
    brd(2'd0, v); chk(v == 16'h0000, "R11", "data port reads 0", v, 0);
    for (int i = 0; i < 18; i++) begin
      x = 8'($urandom); bwr(2'd0, {8'h00, x});
      if (i < 16) expq.push_back(x);
    end
    brd(2'd3, v); chk(v == 16'h1000, "R2", "count saturates at depth R1", v, 16'h1000);
    brd(2'd2, v); chk(v[1] == 1'b0, "R7", "tend cleared by write", v[1], 0);
    chk(tx_req === 1'b1, "R8", "req with flag and enable", tx_req, 1);
    bwr(2'd2, 16'h0000);
    waitn(2);
    brd(2'd2, v); chk(v[0] == 1'b0, "R5", "armed clear", v[0], 0);
    chk(tx_req === 1'b0, "R8", "req after clear", tx_req, 0);

    bwr(2'd1, cw(1, 1, 3, 0));
    do brd(2'd3, v); while (v[15:8] > 8'd9);
    chk(v[15:8] == 8'd9, "R4", "count reaches 9", v[15:8], 9);
    brd(2'd2, v); chk(v[0] == 1'b0, "R4", "flag low above trigger", v[0], 0);
    do brd(2'd3, v); while (v[15:8] > 8'd8);
    waitn(2);
    brd(2'd2, v); chk(v[0] == 1'b1, "R4", "flag at trigger 8", v[0], 1);
    chk(tx_req === 1'b1, "R8", "req follows flag", tx_req, 1);
    wait_rx(16); cmp_rx("R3");
    waitn(2 * TDIV + 4);
    brd(2'd2, v); chk(v[1] == 1'b1, "R7", "tend after last stop", v[1], 1);

    // R9: disable mid-frame
    rxq.delete(); expq.delete();
    bwr(2'd1, cw(1, 0, 0, 0));
    x = 8'hA5; bwr(2'd0, {8'h00, x}); expq.push_back(x);
    while (txd !== 1'b0) @(negedge clk);
    bwr(2'd1, cw(0, 0, 0, 0));
    bwr(2'd0, 16'h003C);
    waitn(200);
    cmp_rx("R9");
    brd(2'd3, v); chk(v[15:8] == 8'd1, "R9", "no new frame while disabled", v[15:8], 1);
    expq.push_back(8'h3C);
    bwr(2'd1, cw(1, 0, 0, 0));
    wait_rx(2); cmp_rx("R9");
    waitn(2 * TDIV + 4);

    // R6: DMA path
    rxq.delete(); expq.delete();
    bwr(2'd1, cw(0, 1, 0, 0));
    waitn(3);
    chk(tx_req === 1'b1, "R8", "req before dma", tx_req, 1);
    dwr(8'h11); dwr(8'h22);
    waitn(3);
    chk(tx_req === 1'b0, "R6", "dma cleared request", tx_req, 0);
    brd(2'd2, v); chk(v[0] == 1'b0, "R6", "dma cleared flag", v[0], 0);
    @(negedge clk); dma_wr = 1; dma_data = 8'h33; bus_wr = 1; bus_addr = 2'd0; bus_wdata = 16'h0044;
    @(negedge clk); dma_wr = 0; bus_wr = 0;
    brd(2'd3, v); chk(v[15:8] == 8'd3, "R6", "collision stores one byte", v[15:8], 3);
    expq.push_back(8'h11); expq.push_back(8'h22); expq.push_back(8'h33);
    bwr(2'd1, cw(1, 0, 0, 0));
    wait_rx(3); cmp_rx("R6");
    waitn(2 * TDIV + 4);

    // random bursts
    for (int it = 0; it < 6; it++) begin
      int sel, n;
      sel = $urandom_range(0, 3); n = $urandom_range(1, 16);
      rxq.delete(); expq.delete();
      bwr(2'd1, cw(0, 0, sel, 0));
      for (int i = 0; i < n; i++) begin x = 8'($urandom); bwr(2'd0, {8'h00, x}); expq.push_back(x); end
      brd(2'd2, v); bwr(2'd2, 16'h0000); waitn(2);
      brd(2'd2, v);
      chk(v[0] == fe_after_clear(n, sel), "R4", "flag after clear vs trigger", v[0], fe_after_clear(n, sel));
      brd(2'd3, v); chk(v[15:8] == 8'(n), "R1", "burst count", v[15:8], n);
      bwr(2'd1, cw(1, 0, sel, 0));
      wait_rx(n); cmp_rx("R3");
      waitn(2 * TDIV + 4);
      brd(2'd2, v); chk(v[1] == 1'b1, "R7", "tend after burst", v[1], 1);
    end

    // R10: break aborts a frame and holds the line
    bwr(2'd1, cw(1, 0, 0, 0));
    bwr(2'd0, 16'h00FF);
    while (txd !== 1'b0) @(negedge clk);
    waitn(20);
    bwr(2'd1, cw(0, 0, 0, 1));
    waitn(40);  chk(txd === 1'b0, "R10", "line low in break", txd, 0);
    waitn(100); chk(txd === 1'b0, "R10", "line still low", txd, 0);
    bwr(2'd1, cw(0, 0, 0, 0));
    waitn(3);   chk(txd === 1'b1, "R10", "line high after release", txd, 1);
    brd(2'd3, v); chk(v[15:8] == 8'd0, "R10", "queue empty after abort", v[15:8], 0);
    brd(2'd2, v); chk(v[1] == 1'b1, "R7", "tend after abort", v[1], 1);
    waitn(3 * TDIV);
    chk(txd === 1'b1, "R10", "no frame resumes", txd, 1);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule